// File: doc/BRIEF.md
# NAND Flash Pin Cycle Sequencer

This block turns one host request at a time into a single raw bus cycle on the pins of a NAND flash device. A request is a command byte, an address byte, a data write or a data read. The block drives the command latch and address latch enables, the active-low write and read strobes, the active-low chip enable and a tristate-controlled data bus. It also captures read data from the bus.

Each cycle has three phases: a latch setup phase, a strobe phase and a hold phase. Each phase takes its length from a 3-bit count supplied on the configuration inputs, and the counts are latched when the request is accepted. A separate watcher synchronises the ready/busy pin and sets a sticky flag on the rising or the falling edge, whichever is selected. It raises an interrupt line when that is enabled.

Host logic issues a request with a valid/acknowledge pair. It watches `busy` and the one-clock `done` pulse and then reads `rd_data` after a read cycle. Higher-level operation sequences are built outside the block, for example a command followed by address bytes and then data.

Top module: `nand_pin_sequencer`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `busy`, `done`, `rb_flag` and `rb_irq` are 0, and `rd_data` is 0.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = data write and 3 = data read. A command cycle holds `nand_cle` high and an address cycle holds `nand_ale` high for every cycle in which `busy` is 1. The strobe falls exactly `cfg_setup` clocks after `busy` rises, and with `cfg_setup` = 0 it is low in the first busy clock.
- R3: The strobe stays low for exactly `cfg_strobe`+1 clocks. It is `nand_re_n` for a read and `nand_we_n` for every other kind, and the other strobe stays high.
- R4: After the strobe rises, `busy` and the latch enable stay high for exactly `cfg_hold`+1 clocks. For non-read kinds the data bus stays driven throughout.
- R5: `busy` is high for exactly `cfg_setup`+`cfg_strobe`+`cfg_hold`+2 clocks. It is followed by a `done` pulse of exactly one clock, during which `busy` is 0.
- R6: A read cycle captures `nand_dq_in` on the last strobe clock, while `nand_re_n` is still low, into `rd_data`. With `cfg_wide` = 0, bits 15:8 of `rd_data` are 0. During a read `nand_dq_oe` is 0.
- R7: For non-read kinds `nand_dq_oe` is 1 while busy. `nand_dq_out` carries `req_data` in full when `cfg_wide` = 1, and bits 7:0 with bits 15:8 at 0 when `cfg_wide` = 0.
- R8: While `cfg_enable` is 0, `req_ack` stays 0 and no cycle starts.
- R9: While a cycle is in progress, a request is not acknowledged and does not alter the cycle's pins.
- R10: `nand_ce_n` follows `ce_ctl` one clock later, where 0 selects the device and 1 deselects it.
- R11: With `cfg_rb_fall` = 0 a rising edge on `nand_rb` sets `rb_flag`, and with 1 a falling edge does. The opposite edge leaves the flag unchanged.
- R12: `rb_flag` stays set until a clock in which `rb_flag_clr` is 1, and then it reads 0. `rb_irq` equals `rb_flag` when `cfg_irq_en` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Master enable for bus cycles |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_setup | input | 3 | Latch setup clocks before the strobe |
| cfg_strobe | input | 3 | Strobe low length minus one |
| cfg_hold | input | 3 | Hold length minus one after the strobe |
| cfg_rb_fall | input | 1 | Ready/busy edge select: 0 rising, 1 falling |
| cfg_irq_en | input | 1 | Interrupt enable for the ready/busy flag |
| ce_ctl | input | 1 | Chip enable control, 0 selects the device |
| rb_flag_clr | input | 1 | Clears the ready/busy flag |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind (see R2) |
| req_data | input | 16 | Command, address or write data |
| req_ack | output | 1 | Request accepted this clock |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 16 | Captured read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_rb | input | 1 | Ready/busy pin |
| rb_flag | output | 1 | Sticky ready/busy edge flag |
| rb_irq | output | 1 | Ready/busy interrupt |

## Verification
The checker takes for granted that `ce_ctl` is held at 1 through reset, so that the one-clock follow relation for chip enable holds from the first edge. It also assumes that `rb_flag_clr` is the only thing that can clear the flag. The stimulus drives every input on the falling clock edge and changes configuration only while the block is idle. It keeps `ce_ctl` at 1 until reset has been released. The bench models the read data bus so that it shows a distinct value whenever the read strobe is high, which exposes a capture outside the strobe window.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_seq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] strobe_len,
    input  logic [CNT_W-1:0] hold_len,
    output phase_e           phase,
    output logic             last_strobe,
    output logic             done
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic             done;
    } timer_t;

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d      = tm_q;
        tm_d.done = 1'b0;
        case (tm_q.phase)
            PH_IDLE: begin
                if (start) begin
                    tm_d.strobe = strobe_len;
                    tm_d.hold   = hold_len;
                    if (setup_len == ZERO) begin
                        tm_d.phase = PH_STROBE;
                        tm_d.cnt   = strobe_len;
                    end else begin
                        tm_d.phase = PH_SETUP;
                        tm_d.cnt   = setup_len - ONE;
                    end
                end
            end
            PH_SETUP: begin
                if (tm_q.cnt == ZERO) begin
                    tm_d.phase = PH_STROBE;
                    tm_d.cnt   = tm_q.strobe;
                end else begin
                    tm_d.cnt = tm_q.cnt - ONE;
                end
            end
            PH_STROBE: begin
                if (tm_q.cnt == ZERO) begin
                    tm_d.phase = PH_HOLD;
                    tm_d.cnt   = tm_q.hold;
                end else begin
                    tm_d.cnt = tm_q.cnt - ONE;
                end
            end
            default: begin
                if (tm_q.cnt == ZERO) begin
                    tm_d.phase = PH_IDLE;
                    tm_d.done  = 1'b1;
                end else begin
                    tm_d.cnt = tm_q.cnt - ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{phase: PH_IDLE, cnt: ZERO, strobe: ZERO, hold: ZERO, done: 1'b0};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign phase       = tm_q.phase;
    assign last_strobe = (tm_q.phase == PH_STROBE) && (tm_q.cnt == ZERO);
    assign done        = tm_q.done;

endmodule

// File: rtl/nand_bus_drive.sv
module nand_bus_drive
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_kind,
    input  logic [DATA_W-1:0] start_data,
    input  logic              wide,
    input  logic              ce_ctl,
    input  phase_e            phase,
    input  logic              last_strobe,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              ce_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        req_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic              wide;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
    } drive_t;

    drive_t dr_d, dr_q;
    logic [DATA_W-1:0] lane_keep;
    logic [DATA_W-1:0] rd_lanes;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_low
                assign lane_keep[LANE_W-1:0] = {LANE_W{1'b1}};
            end else begin : g_high
                assign lane_keep[g*LANE_W +: LANE_W] = {LANE_W{wide}};
            end
        end
    endgenerate

    assign rd_lanes = dq_in & {DATA_W{1'b1}};

    always_comb begin
        dr_d      = dr_q;
        dr_d.ce_n = ce_ctl;
        if (start) begin
            dr_d.kind  = req_kind_e'(start_kind);
            dr_d.wide  = wide;
            dr_d.wdata = start_data & lane_keep;
        end
        if (last_strobe && (dr_q.kind == KIND_READ)) begin
            dr_d.rdata = rd_lanes & lane_mask(dr_q.wide);
        end
    end

    function automatic logic [DATA_W-1:0] lane_mask(input logic w);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i == 0 || w) begin
                m[i*LANE_W +: LANE_W] = {LANE_W{1'b1}};
            end
        end
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '{kind: KIND_CMD, wdata: '0, wide: 1'b0, rdata: '0, ce_n: 1'b1};
        end else begin
            dr_q <= dr_d;
        end
    end

    logic active;
    logic strobing;
    assign active   = (phase != PH_IDLE);
    assign strobing = (phase == PH_STROBE);

    assign cle     = active && (dr_q.kind == KIND_CMD);
    assign ale     = active && (dr_q.kind == KIND_ADDR);
    assign we_n    = !(strobing && (dr_q.kind != KIND_READ));
    assign re_n    = !(strobing && (dr_q.kind == KIND_READ));
    assign dq_oe   = active && (dr_q.kind != KIND_READ);
    assign dq_out  = dr_q.wdata;
    assign rd_data = dr_q.rdata;
    assign ce_n    = dr_q.ce_n;

endmodule

// File: rtl/nand_rb_detect.sv
module nand_rb_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    input  logic edge_fall,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   flag;
    } rb_t;

    rb_t rb_d, rb_q;
    logic synced;
    logic hit;

    assign synced = rb_q.sync[SYNC_STAGES-1];

    always_comb begin
        rb_d      = rb_q;
        rb_d.sync = {rb_q.sync[SYNC_STAGES-2:0], rb_pin};
        rb_d.prev = synced;
        hit       = edge_fall ? (rb_q.prev && !synced) : (!rb_q.prev && synced);
        if (hit) begin
            rb_d.flag = 1'b1;
        end else if (clr) begin
            rb_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '{sync: {SYNC_STAGES{1'b1}}, prev: 1'b1, flag: 1'b0};
        end else begin
            rb_q <= rb_d;
        end
    end

    assign flag = rb_q.flag;
    assign irq  = rb_q.flag && irq_en;

endmodule

// File: rtl/nand_pin_sequencer.sv
module nand_pin_sequencer
    import nand_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_wide,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_rb_fall,
    input  logic              cfg_irq_en,
    input  logic              ce_ctl,
    input  logic              rb_flag_clr,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ack,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_ce_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb,
    output logic              rb_flag,
    output logic              rb_irq
);

    phase_e phase;
    logic   last_strobe;
    logic   accept;

    assign accept  = req_valid && cfg_enable && (phase == PH_IDLE);
    assign req_ack = accept;
    assign busy    = (phase != PH_IDLE);

    nand_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .setup_len   (cfg_setup),
        .strobe_len  (cfg_strobe),
        .hold_len    (cfg_hold),
        .phase       (phase),
        .last_strobe (last_strobe),
        .done        (done)
    );

    nand_bus_drive #(.DATA_W(DATA_W), .LANE_W(DATA_W / 2)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_kind  (req_kind),
        .start_data  (req_data),
        .wide        (cfg_wide),
        .ce_ctl      (ce_ctl),
        .phase       (phase),
        .last_strobe (last_strobe),
        .dq_in       (nand_dq_in),
        .rd_data     (rd_data),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .ce_n        (nand_ce_n),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe)
    );

    nand_rb_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rb_pin    (nand_rb),
        .edge_fall (cfg_rb_fall),
        .clr       (rb_flag_clr),
        .irq_en    (cfg_irq_en),
        .flag      (rb_flag),
        .irq       (rb_irq)
    );

endmodule

// File: rtl/nand_pin_sequencer_checker.sv
module nand_pin_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic ce_ctl,
    input logic rb_flag_clr,
    input logic req_ack,
    input logic busy,
    input logic done,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_ce_n,
    input logic rb_flag
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R3

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2

    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale)); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_NO_ACK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !req_ack); // R8

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ack); // R9

    AST_ACK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy); // R5

    AST_CE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n == $past(ce_ctl)); // R10

    AST_FLAG_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_flag) |-> $past(rb_flag_clr)); // R12

endmodule

bind nand_pin_sequencer nand_pin_sequencer_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .ce_ctl      (ce_ctl),
    .rb_flag_clr (rb_flag_clr),
    .req_ack     (req_ack),
    .busy        (busy),
    .done        (done),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_ce_n   (nand_ce_n),
    .rb_flag     (rb_flag)
);

// File: tb/nand_pin_sequencer_bench.sv
module nand_pin_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [2:0]  cfg_setup = '0;
    logic [2:0]  cfg_strobe = '0;
    logic [2:0]  cfg_hold = '0;
    logic        cfg_rb_fall = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        ce_ctl = 1'b1;
    logic        rb_flag_clr = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_data = '0;
    logic        req_ack, busy, done;
    logic [15:0] rd_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n;
    logic [15:0] nand_dq_out;
    logic        nand_dq_oe;
    logic [15:0] nand_dq_in;
    logic        nand_rb = 1'b1;
    logic        rb_flag, rb_irq;
    logic [15:0] rd_val = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign nand_dq_in = nand_re_n ? 16'hDEAD : rd_val;

    nand_pin_sequencer u_nand_pin_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wide(cfg_wide),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_rb_fall(cfg_rb_fall), .cfg_irq_en(cfg_irq_en), .ce_ctl(ce_ctl),
        .rb_flag_clr(rb_flag_clr), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .req_ack(req_ack), .busy(busy), .done(done),
        .rd_data(rd_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb(nand_rb), .rb_flag(rb_flag), .rb_irq(rb_irq)
    );

    // {kind[27:26], wide[25], setup[24:22], strobe[21:19], hold[18:16], data[15:0]}
    localparam logic [27:0] VEC [6] = '{
        {2'd0, 1'b0, 3'd2, 3'd1, 3'd1, 16'h1270},
        {2'd1, 1'b0, 3'd0, 3'd0, 3'd0, 16'h4433},
        {2'd2, 1'b1, 3'd3, 3'd2, 3'd0, 16'hBEEF},
        {2'd2, 1'b0, 3'd7, 3'd7, 3'd7, 16'hBEEF},
        {2'd3, 1'b1, 3'd1, 3'd3, 3'd2, 16'hA5C3},
        {2'd3, 1'b0, 3'd0, 3'd0, 3'd0, 16'h5A96}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done,
             rb_flag, rb_irq} == 10'b1110000000 && rd_data == 16'h0, "R1",
            {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done}, 8'hE0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 requests ignored while disabled
        begin
            bit saw = 1'b0;
            req_valid = 1'b1;
            req_kind  = 2'd0;
            for (int i = 0; i < 4; i++) begin
                #1;
                if (req_ack || busy || nand_cle) saw = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(!saw && !busy, "R8", saw, 0);
        end
        cfg_enable = 1'b1;

        // Vector table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            logic [1:0]  k;
            logic        w;
            logic [2:0]  su, st, ho;
            logic [15:0] dat, exp_d;
            int pre, slow, post, total, bad_ctl, bad_data, bad_other, n;
            bit got_ack, seen_strobe, strobe_low, ctl;
            {k, w, su, st, ho, dat} = VEC[v];
            exp_d = w ? dat : {8'h00, dat[7:0]};
            cfg_wide = w; cfg_setup = su; cfg_strobe = st; cfg_hold = ho;
            rd_val = dat;
            req_kind = k; req_data = dat; req_valid = 1'b1;
            #1 got_ack = req_ack;
            @(negedge clk);
            req_valid = 1'b0;
            chk(got_ack, "R5 ack", got_ack, 1);
            pre = 0; slow = 0; post = 0; total = 0; bad_ctl = 0; bad_data = 0; bad_other = 0;
            seen_strobe = 1'b0; n = 0;
            while (!done && n < 60) begin
                if (busy) begin
                    total++;
                    strobe_low = (k == 2'd3) ? !nand_re_n : !nand_we_n;
                    if ((k == 2'd3) ? !nand_we_n : !nand_re_n) bad_other++;
                    ctl = (k == 2'd0) ? nand_cle : (k == 2'd1) ? nand_ale : 1'b1;
                    if (!ctl) bad_ctl++;
                    if (k != 2'd3) begin
                        if (!nand_dq_oe || nand_dq_out != exp_d) bad_data++;
                    end else if (nand_dq_oe) begin
                        bad_data++;
                    end
                    if (strobe_low) begin slow++; seen_strobe = 1'b1; end
                    else if (!seen_strobe) pre++;
                    else post++;
                end
                @(negedge clk);
                n++;
            end
            chk(pre == su && bad_ctl == 0, "R2", pre, su);
            chk(slow == st + 1 && bad_other == 0, "R3", slow, st + 1);
            chk(post == ho + 1, "R4", post, ho + 1);
            chk(done && !busy && total == su + st + ho + 2, "R5", total, su + st + ho + 2);
            if (k == 2'd3) chk(rd_data == exp_d && bad_data == 0, "R6", rd_data, exp_d);
            else           chk(bad_data == 0, "R7", bad_data, 0);
            @(negedge clk);
            chk(!done, "R5 single", done, 0);
        end

        // R9 request during a cycle is ignored
        begin
            bit got_ack;
            bit bad = 1'b0;
            int n = 0;
            cfg_setup = 3'd5; cfg_strobe = 3'd1; cfg_hold = 3'd1;
            req_kind = 2'd0; req_data = 16'h0011; req_valid = 1'b1;
            @(negedge clk);
            req_kind = 2'd1;
            for (int i = 0; i < 3; i++) begin
                #1 if (req_ack || nand_ale || !nand_cle) bad = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
            while (!done && n < 40) begin @(negedge clk); n++; end
            got_ack = !bad;
            chk(got_ack && done, "R9", bad, 0);
        end

        // R10 chip enable follows control
        ce_ctl = 1'b0;
        @(negedge clk);
        chk(nand_ce_n == 1'b0, "R10 select", nand_ce_n, 0);
        ce_ctl = 1'b1;
        @(negedge clk);
        chk(nand_ce_n == 1'b1, "R10 deselect", nand_ce_n, 1);

        // R11 edge select
        cfg_rb_fall = 1'b0;
        nand_rb = 1'b0;
        repeat (5) @(negedge clk);
        chk(!rb_flag, "R11 falling ignored", rb_flag, 0);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        chk(rb_flag, "R11 rising sets", rb_flag, 1);

        // R12 sticky, irq gating, clear
        repeat (3) @(negedge clk);
        chk(rb_flag && !rb_irq, "R12 sticky no irq", rb_irq, 0);
        cfg_irq_en = 1'b1;
        #1 chk(rb_irq, "R12 irq", rb_irq, 1);
        @(negedge clk);
        rb_flag_clr = 1'b1;
        @(negedge clk);
        rb_flag_clr = 1'b0;
        chk(!rb_flag && !rb_irq, "R12 clear", rb_flag, 0);

        cfg_rb_fall = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rb_flag, "R11 select change no edge", rb_flag, 0);
        nand_rb = 1'b0;
        repeat (5) @(negedge clk);
        chk(rb_flag, "R11 falling sets", rb_flag, 1);

        finish_run();
    end

endmodule